// File: doc/BRIEF.md
# Power-On Start-Up Mode Strap Sampler

This block decides how a device boots when its active-low power-down input is released. Three strap pins (the mode strap and the two status straps) each reach the block as a two-bit code for a three-level input: low, mid or high. An analog front end outside the block produces that code. A small group of GPIO straps picks a ROM page. The block captures all straps once, at power-up. From the captured values it chooses where the register file is initialized from (an EEPROM model or one page of a ROM model) and which serial interface is active (I2C or SPI).

After capture, the block copies a fixed number of words from the chosen source into an internal register file, one word per clock. It then raises a load-done flag. At the same moment it enables the output drivers of the two status pins, because those pins now stop acting as straps and start acting as outputs. It also reports when the GPIO pins may take up their post-reset functions. That permission depends on the start-up mode and, in ROM mode, on a control bit inside the loaded register image. A read port lets the loaded register image be inspected.

Top module: `strap_boot_ctrl`

## Requirements
- R1: Strap level codes are 2'b00 low, 2'b01 mid, 2'b10 high, and 2'b11 is decoded as low. Straps are captured on the first rising clock edge after `pwr_n` goes high. Later strap changes leave `boot_mode`, `spi_sel`, `rom_page` and `strap_err` unchanged until the next power-down.
- R2: A low mode strap gives `boot_mode` = 0 (EEPROM source, I2C) with `spi_sel` = 0.
- R3: A mid mode strap with both status straps also mid gives `boot_mode` = 1 (EEPROM source, SPI) with `spi_sel` = 1.
- R4: A high mode strap gives `boot_mode` = 2 (ROM source, I2C) with `spi_sel` = 0. In this mode `rom_page` equals the captured `gpio_strap`; in other modes `rom_page` is 0.
- R5: A mid mode strap with either status strap not mid falls back to `boot_mode` = 0 with `strap_err` = 1. In every other case `strap_err` is 0.
- R6: While `pwr_n` is low, `load_done`, `stat_oe`, `boot_mode`, `spi_sel` and `strap_err` are 0, and every register-file word reads 0.
- R7: Loading writes one word per clock for LOAD_WORDS words. `load_done` rises on clock edge LOAD_WORDS+1 counted from release, with edge 1 being the capture edge. For DATA_W = 8, EEPROM word i is (0xA5 ^ i*0x1D) mod 256. ROM word i of page p is ((p<<6) ^ i*0x15 ^ 0x0F) mod 256.
- R8: `stat_oe` is 2'b11 when `load_done` is 1 and 2'b00 otherwise.
- R9: `gpio_soft_en` equals `load_done` in modes 0 and 1. In ROM mode it equals `load_done` AND the most significant bit of loaded register word 0.
- R10: Once set, `load_done` stays 1 until `pwr_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_n | input | 1 | Active-low power-down; low holds the block cleared, rising edge starts capture |
| mode_lvl | input | 2 | Mode strap level code |
| stat0_lvl | input | 2 | Status strap 0 level code |
| stat1_lvl | input | 2 | Status strap 1 level code |
| gpio_strap | input | PAGE_W | ROM page select straps |
| rd_addr | input | ADDR_W | Register-file read address |
| rd_data | output | DATA_W | Register-file read data |
| boot_mode | output | 2 | Captured start-up mode: 0 EEPROM/I2C, 1 EEPROM/SPI, 2 ROM/I2C |
| spi_sel | output | 1 | 1 when the SPI interface is selected |
| rom_page | output | PAGE_W | Captured ROM page |
| strap_err | output | 1 | Inconsistent SPI strap set detected |
| load_done | output | 1 | Register load finished |
| stat_oe | output | 2 | Output enables of the two status pins |
| gpio_soft_en | output | 1 | GPIO pins may take their post-reset functions |

## Verification
The hardest case to reach is a strap change after capture. From the ports it looks the same as a legitimate capture, unless the change lands exactly one edge after the capture edge while the loader is still busy. The bench therefore changes every strap and the GPIO page at the falling edge right after the capture edge. It then checks that the mode outputs hold, and that the loaded words still match the originally chosen source and page. A second hard case is the ROM-mode GPIO permission, which hinges on one bit of the loaded image. The bench boots two ROM pages, one whose first word has its top bit set and one whose first word does not.

// File: rtl/strap_boot_pkg.sv
package strap_boot_pkg;

   typedef enum logic [1:0] {
      LVL_LO  = 2'b00,
      LVL_MID = 2'b01,
      LVL_HI  = 2'b10,
      LVL_BAD = 2'b11
   } lvl_e;

   typedef enum logic [1:0] {
      BM_EE_I2C  = 2'd0,
      BM_EE_SPI  = 2'd1,
      BM_ROM_I2C = 2'd2
   } boot_mode_e;

   // EEPROM image model: word i
   function automatic logic [31:0] ee_word(input int i);
      return 32'h0000_00A5 ^ (32'(i) * 32'h1D);
   endfunction

   // ROM image model: page index sits in the top PW bits of a DW-bit word
   function automatic logic [31:0] rom_word(input int p, input int i,
                                            input int dw, input int pw);
      return (32'(p) << (dw - pw)) ^ (32'(i) * 32'h15) ^ 32'h0000_000F;
   endfunction

endpackage

// File: rtl/strap_decode.sv
module strap_decode
   import strap_boot_pkg::*;
(
   input  logic [1:0] mode_lvl,
   input  logic [1:0] stat0_lvl,
   input  logic [1:0] stat1_lvl,
   output logic [1:0] mode,
   output logic       err
);
   logic all_mid;

   always_comb begin
      all_mid = (stat0_lvl == LVL_MID) && (stat1_lvl == LVL_MID);
      mode    = BM_EE_I2C;
      err     = 1'b0;
      case (mode_lvl)
         LVL_HI:  mode = BM_ROM_I2C;
         LVL_MID: begin
            if (all_mid) mode = BM_EE_SPI;
            else         err  = 1'b1;
         end
         default: mode = BM_EE_I2C;
      endcase
   end
endmodule

// File: rtl/boot_loader.sv
module boot_loader
   import strap_boot_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LOAD_WORDS = 8,
   parameter int PAGE_W     = 2,
   parameter int ADDR_W     = $clog2(LOAD_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rom_sel,
   input  logic [PAGE_W-1:0] page,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              done
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LOAD_WORDS - 1);

   logic [ADDR_W-1:0] idx_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         done_q <= 1'b0;
      end else if (start && !done_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST) done_q <= 1'b1;
      end
   end

   always_comb begin
      wr_en   = start && !done_q;
      wr_addr = idx_q;
      wr_data = rom_sel ? DATA_W'(rom_word(int'(page), int'(idx_q), DATA_W, PAGE_W))
                        : DATA_W'(ee_word(int'(idx_q)));
   end

   assign done = done_q;
endmodule

// File: rtl/boot_regfile.sv
module boot_regfile #(
   parameter int DATA_W     = 8,
   parameter int LOAD_WORDS = 8,
   parameter int ADDR_W     = $clog2(LOAD_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              ctrl_msb
);
   logic [DATA_W-1:0] rows [LOAD_WORDS];

   for (genvar r = 0; r < LOAD_WORDS; r++) begin : g_row
      logic [DATA_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                row_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(r))   row_q <= wr_data;
      end
      assign rows[r] = row_q;
   end

   assign rd_data  = (32'(rd_addr) < LOAD_WORDS) ? rows[rd_addr] : '0;
   assign ctrl_msb = rows[0][DATA_W-1];
endmodule

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl
   import strap_boot_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LOAD_WORDS = 8,
   parameter int PAGE_W     = 2,
   parameter int ADDR_W     = $clog2(LOAD_WORDS)
) (
   input  logic              clk,
   input  logic              pwr_n,
   input  logic [1:0]        mode_lvl,
   input  logic [1:0]        stat0_lvl,
   input  logic [1:0]        stat1_lvl,
   input  logic [PAGE_W-1:0] gpio_strap,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        boot_mode,
   output logic              spi_sel,
   output logic [PAGE_W-1:0] rom_page,
   output logic              strap_err,
   output logic              load_done,
   output logic [1:0]        stat_oe,
   output logic              gpio_soft_en
);
   if (LOAD_WORDS < 2)            begin : g_bad_words  $error("LOAD_WORDS must be at least 2"); end
   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width  $error("DATA_W must lie in 2..32"); end
   if (PAGE_W < 1 || PAGE_W >= DATA_W) begin : g_bad_page $error("PAGE_W must lie in 1..DATA_W-1"); end
   if ((1 << ADDR_W) < LOAD_WORDS) begin : g_bad_addr  $error("ADDR_W too small for LOAD_WORDS"); end

   logic [1:0]        dec_mode;
   logic              dec_err;
   logic              armed_q;
   logic [1:0]        mode_q;
   logic [PAGE_W-1:0] page_q;
   logic              err_q;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              done;
   logic              ctrl_msb;

   strap_decode u_dec (
      .mode_lvl  (mode_lvl),
      .stat0_lvl (stat0_lvl),
      .stat1_lvl (stat1_lvl),
      .mode      (dec_mode),
      .err       (dec_err)
   );

   // one-shot capture on the first edge after power-down release
   always_ff @(posedge clk or negedge pwr_n) begin
      if (!pwr_n) begin
         armed_q <= 1'b0;
         mode_q  <= BM_EE_I2C;
         page_q  <= '0;
         err_q   <= 1'b0;
      end else if (!armed_q) begin
         armed_q <= 1'b1;
         mode_q  <= dec_mode;
         page_q  <= (dec_mode == BM_ROM_I2C) ? gpio_strap : '0;
         err_q   <= dec_err;
      end
   end

   boot_loader #(
      .DATA_W     (DATA_W),
      .LOAD_WORDS (LOAD_WORDS),
      .PAGE_W     (PAGE_W),
      .ADDR_W     (ADDR_W)
   ) u_load (
      .clk     (clk),
      .rst_n   (pwr_n),
      .start   (armed_q),
      .rom_sel (mode_q == BM_ROM_I2C),
      .page    (page_q),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .done    (done)
   );

   boot_regfile #(
      .DATA_W     (DATA_W),
      .LOAD_WORDS (LOAD_WORDS),
      .ADDR_W     (ADDR_W)
   ) u_rf (
      .clk      (clk),
      .rst_n    (pwr_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .ctrl_msb (ctrl_msb)
   );

   always_comb begin
      boot_mode    = mode_q;
      spi_sel      = (mode_q == BM_EE_SPI);
      rom_page     = page_q;
      strap_err    = err_q;
      load_done    = done;
      stat_oe      = {2{done}};
      gpio_soft_en = done && ((mode_q != BM_ROM_I2C) || ctrl_msb);
   end
endmodule

// File: rtl/strap_boot_ctrl_chk.sv
module strap_boot_ctrl_chk #(
   parameter int LOAD_WORDS = 8,
   parameter int PAGE_W     = 2
) (
   input logic              clk,
   input logic              pwr_n,
   input logic [1:0]        boot_mode,
   input logic              spi_sel,
   input logic [PAGE_W-1:0] rom_page,
   input logic              strap_err,
   input logic              load_done,
   input logic [1:0]        stat_oe
);
   logic [15:0] cyc;

   always_ff @(posedge clk or negedge pwr_n) begin
      if (!pwr_n)             cyc <= '0;
      else if (cyc != 16'hFFFF) cyc <= cyc + 16'd1;
   end

   p_quiet_pd_r6: assert property (@(posedge clk)
      !pwr_n |-> (!load_done && stat_oe == 2'b00 && boot_mode == 2'd0 && !spi_sel && !strap_err));

   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!pwr_n)
      (cyc >= 16'd2) |-> ($stable(boot_mode) && $stable(spi_sel) && $stable(rom_page) && $stable(strap_err)));

   p_load_len_r7: assert property (@(posedge clk) disable iff (!pwr_n)
      $rose(load_done) |-> (32'(cyc) == LOAD_WORDS + 1));

   p_oe_late_r8: assert property (@(posedge clk) disable iff (!pwr_n)
      (stat_oe != 2'b00) |-> load_done);

   p_done_hold_r10: assert property (@(posedge clk) disable iff (!pwr_n)
      load_done |=> load_done);

   p_spi_clean_r3: assert property (@(posedge clk) disable iff (!pwr_n)
      spi_sel |-> !strap_err);

   p_err_mode_r5: assert property (@(posedge clk) disable iff (!pwr_n)
      strap_err |-> (boot_mode == 2'd0));
endmodule

bind strap_boot_ctrl strap_boot_ctrl_chk #(
   .LOAD_WORDS (LOAD_WORDS),
   .PAGE_W     (PAGE_W)
) u_chk (
   .clk       (clk),
   .pwr_n     (pwr_n),
   .boot_mode (boot_mode),
   .spi_sel   (spi_sel),
   .rom_page  (rom_page),
   .strap_err (strap_err),
   .load_done (load_done),
   .stat_oe   (stat_oe)
);

// File: tb/strap_boot_ctrl_bench.sv
module strap_boot_ctrl_bench;
   localparam int DW = 8;
   localparam int NW = 8;
   localparam int PW = 2;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          pwr_n = 1'b0;
   logic [1:0]    mode_lvl = 2'b00, stat0_lvl = 2'b00, stat1_lvl = 2'b00;
   logic [PW-1:0] gpio_strap = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [1:0]    boot_mode;
   logic          spi_sel;
   logic [PW-1:0] rom_page;
   logic          strap_err;
   logic          load_done;
   logic [1:0]    stat_oe;
   logic          gpio_soft_en;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   strap_boot_ctrl u_strap_boot_ctrl (
      .clk(clk), .pwr_n(pwr_n), .mode_lvl(mode_lvl), .stat0_lvl(stat0_lvl),
      .stat1_lvl(stat1_lvl), .gpio_strap(gpio_strap), .rd_addr(rd_addr),
      .rd_data(rd_data), .boot_mode(boot_mode), .spi_sel(spi_sel),
      .rom_page(rom_page), .strap_err(strap_err), .load_done(load_done),
      .stat_oe(stat_oe), .gpio_soft_en(gpio_soft_en)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_word(input bit rom, input int p, input int i);
      if (rom) return 8'((p << 6) ^ (i * 21) ^ 15);
      return 8'(165 ^ (i * 29));
   endfunction

   // full boot with checks; disturb changes straps right after capture
   task automatic boot(input logic [1:0] m, input logic [1:0] s0, input logic [1:0] s1,
                       input logic [PW-1:0] g, input logic [1:0] e_mode, input bit e_spi,
                       input bit e_err, input bit disturb, input string tag);
      bit rom = (e_mode == 2'd2);
      int pg = rom ? int'(g) : 0;
      @(negedge clk) pwr_n = 1'b0;
      mode_lvl = m; stat0_lvl = s0; stat1_lvl = s1; gpio_strap = g;
      @(negedge clk);
      chk({tag, " R6 done low in power-down"}, 32'(load_done), 0);
      chk({tag, " R6 oe off in power-down"}, 32'(stat_oe), 0);
      rd_addr = 3'd1; #1;
      chk({tag, " R6 regfile cleared"}, 32'(rd_data), 0);
      @(negedge clk) pwr_n = 1'b1;
      @(negedge clk);                     // after capture edge 1
      chk({tag, " R1/R2/R3/R4 mode"}, 32'(boot_mode), 32'(e_mode));
      chk({tag, " R3 spi_sel"}, 32'(spi_sel), 32'(e_spi));
      chk({tag, " R5 strap_err"}, 32'(strap_err), 32'(e_err));
      chk({tag, " R4 rom_page"}, 32'(rom_page), 32'(pg));
      if (disturb) begin
         mode_lvl = ~m; stat0_lvl = 2'b01 ^ s0; stat1_lvl = 2'b10; gpio_strap = ~g;
      end
      repeat (NW - 1) @(negedge clk);     // after edge NW
      chk({tag, " R7 done not early"}, 32'(load_done), 0);
      chk({tag, " R8 oe off before done"}, 32'(stat_oe), 0);
      @(negedge clk);                     // after edge NW+1
      chk({tag, " R7 done on time"}, 32'(load_done), 1);
      chk({tag, " R8 oe on"}, 32'(stat_oe), 3);
      chk({tag, " R9 gpio_soft_en"}, 32'(gpio_soft_en),
          rom ? 32'(exp_word(1'b1, pg, 0) >> 7) : 1);
      chk({tag, " R1 mode held"}, 32'(boot_mode), 32'(e_mode));
      chk({tag, " R1 page held"}, 32'(rom_page), 32'(pg));
      for (int i = 0; i < NW; i++) begin
         rd_addr = AW'(i); #1;
         chk({tag, " R7 word"}, 32'(rd_data), 32'(exp_word(rom, pg, i)));
      end
      repeat (5) @(negedge clk);
      chk({tag, " R10 done held"}, 32'(load_done), 1);
   endtask

   task automatic t_ee_i2c();   boot(2'b00, 2'b00, 2'b10, 2'd3, 2'd0, 0, 0, 0, "ee_i2c");  endtask
   task automatic t_bad_code(); boot(2'b11, 2'b01, 2'b01, 2'd1, 2'd0, 0, 0, 0, "code11"); endtask
   task automatic t_ee_spi();   boot(2'b01, 2'b01, 2'b01, 2'd2, 2'd1, 1, 0, 0, "ee_spi");  endtask
   task automatic t_rom_hi();   boot(2'b10, 2'b00, 2'b00, 2'd2, 2'd2, 0, 0, 0, "rom_p2");  endtask
   task automatic t_rom_lo();   boot(2'b10, 2'b10, 2'b01, 2'd1, 2'd2, 0, 0, 0, "rom_p1");  endtask
   task automatic t_fallback(); boot(2'b01, 2'b01, 2'b00, 2'd0, 2'd0, 0, 1, 0, "fallbk");  endtask
   task automatic t_disturb();  boot(2'b10, 2'b00, 2'b00, 2'd3, 2'd2, 0, 0, 1, "disturb"); endtask

   // power-down in the middle of a load clears everything
   task automatic t_abort();
      @(negedge clk) pwr_n = 1'b0;
      mode_lvl = 2'b10; gpio_strap = 2'd3;
      @(negedge clk) pwr_n = 1'b1;
      repeat (4) @(negedge clk);
      pwr_n = 1'b0; #1;
      chk("abort R6 done", 32'(load_done), 0);
      chk("abort R6 mode", 32'(boot_mode), 0);
      rd_addr = 3'd0; #1;
      chk("abort R6 word0", 32'(rd_data), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("reset R6 done", 32'(load_done), 0);
      chk("reset R6 oe", 32'(stat_oe), 0);
      chk("reset R6 spi", 32'(spi_sel), 0);
      chk("reset R9 gpio_soft_en", 32'(gpio_soft_en), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_ee_i2c();
      t_bad_code();
      t_ee_spi();
      t_rom_hi();
      t_rom_lo();
      t_fallback();
      t_disturb();
      t_abort();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule